// File: doc/BRIEF.md
# Morse Letter Pulse Transmitter

This block sends one letter of the Latin alphabet as timed Morse code on a single on/off line. That line can drive a lamp and a relay together, so the code can be seen and heard. A 5-bit letter code selects the letter. A one-cycle start pulse, sampled while the block is idle, accepts the letter. An internal table gives each letter a dot/dash pattern of one to four symbols and a symbol count. A state machine then plays the symbols in order against a slow time unit. A prescaler produces that unit from the system clock.

The default time unit is 25,000,000 clock cycles, which is half a second at 50 MHz. A parameter sets this count, so a short unit can be used for fast runs. The pattern and count of the accepted letter stay on two output buses for a display. A one-cycle done flag marks the end of each letter. The start, letter and status pins are plain control signals, with no handshake. A start that arrives while a letter is playing is dropped, not held back.

Top module: `morse_tx`

## Requirements
- R1: Letter codes 0 to 25 select A to Z. When a start is accepted, `pattern_o` and `length_o` show the letter's code from the next cycle. Bit i of `pattern_o` is symbol i, where 0 is a dot and 1 is a dash and bit 0 is sent first. `length_o` holds the symbol count, 1 to 4. Both stay unchanged until the next accepted start.
- R2: A dot holds `tone_o` high for one time unit (TICK_CYCLES cycles). A dash holds it high for three time units.
- R3: Symbols are sent from bit 0 up to the last counted symbol. Between two symbols of a letter, `tone_o` is low for exactly one time unit.
- R4: A start pulse while idle with a valid code sets `tone_o` and `busy_o` high in the first cycle after the accepting clock edge.
- R5: Accepting a start restarts the prescaler. The first symbol therefore lasts full time units, whatever the prescaler phase was when the start arrived.
- R6: In the cycle after the last symbol's on-time ends, `done_o` is high for exactly one cycle. In that same cycle `busy_o` and `tone_o` are low.
- R7: A start pulse while `busy_o` is high is ignored. The tone timing, `pattern_o` and `length_o` do not change.
- R8: Codes 26 to 31 are invalid. A start with one of them keeps `tone_o` and `busy_o` low and sets `pattern_o` and `length_o` to 0. It also pulses `done_o` for one cycle, in the first cycle after the accepting edge.
- R9: An active-low `rst_n`, asynchronous, forces `tone_o`, `busy_o` and `done_o` low and clears `pattern_o` and `length_o` to 0. The block then waits idle for a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; acted on only while idle |
| letter_i | input | 5 | Letter code, 0 = A through 25 = Z |
| tone_o | output | 1 | On/off line for the lamp and relay |
| busy_o | output | 1 | High while a letter is playing |
| done_o | output | 1 | One-cycle end-of-letter flag |
| pattern_o | output | 4 | Dot/dash bits of the accepted letter |
| length_o | output | 3 | Symbol count of the accepted letter |

## Verification
Take the clock edge that accepts a start as cycle 0. The tone, busy and display outputs are then due in cycle 1, because each passes through one register. From there the tone follows the letter's dot, dash and gap sequence in multiples of TICK_CYCLES. The done flag rises in the cycle after the last on-time ends. For an invalid code it rises in cycle 1. The bench sweeps all 32 codes with a four-cycle unit and waits a varying number of idle cycles before each start, so the prescaler phase differs from run to run. It builds each letter's expected per-cycle tone, busy and done sequence arithmetically, then compares it at every falling clock edge after the accepting edge, one cycle at a time.

// File: rtl/morse_pkg.sv
package morse_pkg;
  localparam int SYM_MAX = 4;
  localparam int LEN_W   = $clog2(SYM_MAX + 1);
  localparam int IDX_W   = $clog2(SYM_MAX);
  localparam int CODE_W  = 5;
  localparam int LETTERS = 26;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MARK  = 2'd1,
    ST_SPACE = 2'd2
  } tx_state_e;
endpackage

// File: rtl/morse_code_rom.sv
module morse_code_rom
  import morse_pkg::*;
(
  input  logic [CODE_W-1:0]  letter_i,
  output logic [SYM_MAX-1:0] pattern_o,
  output logic [LEN_W-1:0]   length_o,
  output logic               valid_o
);
  // bit 0 is the first symbol; 1 = dash, 0 = dot
  always_comb begin
    valid_o = 1'b1;
    unique case (letter_i)
      5'd0:  begin pattern_o = 4'b0010; length_o = 3'd2; end
      5'd1:  begin pattern_o = 4'b0001; length_o = 3'd4; end
      5'd2:  begin pattern_o = 4'b0101; length_o = 3'd4; end
      5'd3:  begin pattern_o = 4'b0001; length_o = 3'd3; end
      5'd4:  begin pattern_o = 4'b0000; length_o = 3'd1; end
      5'd5:  begin pattern_o = 4'b0100; length_o = 3'd4; end
      5'd6:  begin pattern_o = 4'b0011; length_o = 3'd3; end
      5'd7:  begin pattern_o = 4'b0000; length_o = 3'd4; end
      5'd8:  begin pattern_o = 4'b0000; length_o = 3'd2; end
      5'd9:  begin pattern_o = 4'b1110; length_o = 3'd4; end
      5'd10: begin pattern_o = 4'b0101; length_o = 3'd3; end
      5'd11: begin pattern_o = 4'b0010; length_o = 3'd4; end
      5'd12: begin pattern_o = 4'b0011; length_o = 3'd2; end
      5'd13: begin pattern_o = 4'b0001; length_o = 3'd2; end
      5'd14: begin pattern_o = 4'b0111; length_o = 3'd3; end
      5'd15: begin pattern_o = 4'b0110; length_o = 3'd4; end
      5'd16: begin pattern_o = 4'b1011; length_o = 3'd4; end
      5'd17: begin pattern_o = 4'b0010; length_o = 3'd3; end
      5'd18: begin pattern_o = 4'b0000; length_o = 3'd3; end
      5'd19: begin pattern_o = 4'b0001; length_o = 3'd1; end
      5'd20: begin pattern_o = 4'b0100; length_o = 3'd3; end
      5'd21: begin pattern_o = 4'b1000; length_o = 3'd4; end
      5'd22: begin pattern_o = 4'b0110; length_o = 3'd3; end
      5'd23: begin pattern_o = 4'b1001; length_o = 3'd4; end
      5'd24: begin pattern_o = 4'b1101; length_o = 3'd4; end
      5'd25: begin pattern_o = 4'b0011; length_o = 3'd4; end
      default: begin pattern_o = '0; length_o = '0; valid_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/morse_unit_timer.sv
module morse_unit_timer #(
  parameter int TICK_CYCLES = 25_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  localparam int CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (restart_i)     cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (TICK_CYCLES > 1) begin : g_chk
      assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
      assert_restart_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/morse_player.sv
module morse_player
  import morse_pkg::*;
#(
  parameter int DASH_UNITS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               start_i,
  input  logic [SYM_MAX-1:0] rom_pattern_i,
  input  logic [LEN_W-1:0]   rom_length_i,
  input  logic               rom_valid_i,
  output logic               restart_o,
  output logic               tone_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [SYM_MAX-1:0] pattern_o,
  output logic [LEN_W-1:0]   length_o
);
  localparam int UW = $clog2(DASH_UNITS + 1);
  localparam logic [UW-1:0] DASH_LEFT = UW'(DASH_UNITS - 1);

  tx_state_e          state_q;
  logic [IDX_W-1:0]   idx_q;
  logic [UW-1:0]      units_q;
  logic [SYM_MAX-1:0] pat_q;
  logic [LEN_W-1:0]   len_q;
  logic               done_q;
  logic [IDX_W-1:0]   idx_nxt;
  logic               last_sym;

  assign idx_nxt   = idx_q + 1'b1;
  assign last_sym  = (LEN_W'(idx_q) + 1'b1 == len_q);
  assign restart_o = (state_q == ST_IDLE) && start_i;
  assign tone_o    = (state_q == ST_MARK);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign pattern_o = pat_q;
  assign length_o  = len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      units_q <= '0;
      pat_q   <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (rom_valid_i) begin
            pat_q   <= rom_pattern_i;
            len_q   <= rom_length_i;
            idx_q   <= '0;
            units_q <= rom_pattern_i[0] ? DASH_LEFT : '0;
            state_q <= ST_MARK;
          end else begin
            pat_q  <= '0;
            len_q  <= '0;
            done_q <= 1'b1;
          end
        end
        ST_MARK: if (tick_i) begin
          if (units_q != '0) begin
            units_q <= units_q - 1'b1;
          end else if (last_sym) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_SPACE;
          end
        end
        ST_SPACE: if (tick_i) begin
          idx_q   <= idx_nxt;
          units_q <= pat_q[idx_nxt] ? DASH_LEFT : '0;
          state_q <= ST_MARK;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_mark_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MARK && !tick_i) |=> state_q == ST_MARK);
  assert_gap_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SPACE && !tick_i) |=> state_q == ST_SPACE);
  assert_idx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (LEN_W'(idx_q) < len_q));
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_display_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(pat_q) && $stable(len_q)));
endmodule

// File: rtl/morse_tx.sv
module morse_tx
  import morse_pkg::*;
#(
  parameter int TICK_CYCLES = 25_000_000,
  parameter int DASH_UNITS  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [CODE_W-1:0]  letter_i,
  output logic               tone_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [SYM_MAX-1:0] pattern_o,
  output logic [LEN_W-1:0]   length_o
);
  logic [SYM_MAX-1:0] rom_pat;
  logic [LEN_W-1:0]   rom_len;
  logic               rom_valid;
  logic               tick;
  logic               restart;

  morse_code_rom u_rom (
    .letter_i (letter_i),
    .pattern_o(rom_pat),
    .length_o (rom_len),
    .valid_o  (rom_valid)
  );

  morse_unit_timer #(.TICK_CYCLES(TICK_CYCLES)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart_i(restart),
    .tick_o   (tick)
  );

  morse_player #(.DASH_UNITS(DASH_UNITS)) u_player (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick),
    .start_i      (start_i),
    .rom_pattern_i(rom_pat),
    .rom_length_i (rom_len),
    .rom_valid_i  (rom_valid),
    .restart_o    (restart),
    .tone_o       (tone_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .pattern_o    (pattern_o),
    .length_o     (length_o)
  );

  assert_invalid_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !rom_valid) |=> (!tone_o && done_o));
endmodule

// File: tb/test_morse_tx.sv
`timescale 1ns/1ps
module test_morse_tx;
  localparam int T = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [4:0] letter_i = '0;
  logic       tone_o, busy_o, done_o;
  logic [3:0] pattern_o;
  logic [2:0] length_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  morse_tx #(.TICK_CYCLES(T)) i_morse_tx (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .letter_i(letter_i),
    .tone_o(tone_o), .busy_o(busy_o), .done_o(done_o),
    .pattern_o(pattern_o), .length_o(length_o)
  );

  function automatic string code_str(input int c);
    case (c)
      0: return ".-";    1: return "-...";  2: return "-.-.";  3: return "-..";
      4: return ".";     5: return "..-.";  6: return "--.";   7: return "....";
      8: return "..";    9: return ".---";  10: return "-.-";  11: return ".-..";
      12: return "--";   13: return "-.";   14: return "---";  15: return ".--.";
      16: return "--.-"; 17: return ".-.";  18: return "...";  19: return "-";
      20: return "..-";  21: return "...-"; 22: return ".--";  23: return "-..-";
      24: return "-.--"; 25: return "--..";
      default: return "";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ignore_at >= 0: pulse start with another letter at that sample
  task automatic play(input int code, input int pre_idle, input int ignore_at);
    string s = code_str(code);
    int len = s.len();
    logic exp_t [0:127];
    int total = 0;
    logic [3:0] exp_pat = '0;
    for (int i = 0; i < len; i++) begin
      int dur = (s[i] == "-") ? 3 * T : T;
      if (s[i] == "-") exp_pat[i] = 1'b1;
      for (int k = 0; k < dur; k++) exp_t[total++] = 1'b1;
      if (i < len - 1) for (int k = 0; k < T; k++) exp_t[total++] = 1'b0;
    end
    repeat (pre_idle) @(negedge clk);
    letter_i = 5'(code);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (len == 0) begin
      check(!tone_o, "R8 tone", tone_o, 0);
      check(!busy_o, "R8 busy", busy_o, 0);
      check(done_o, "R8 done", done_o, 1);
      check(pattern_o == 0 && length_o == 0, "R8 display", {pattern_o, 1'b0, length_o}, 0);
      @(negedge clk);
      check(!done_o && !tone_o, "R8 done single", done_o, 0);
      return;
    end
    for (int j = 0; j <= total; j++) begin
      logic et = (j < total) ? exp_t[j] : 1'b0;
      string tag = (j == 0) ? "R4 tone" : ((j < T) ? "R5 first unit" : "R2 R3 tone");
      check(tone_o == et, tag, tone_o, et);
      check(busy_o == (j < total), (j == total) ? "R6 busy" : "R4 busy", busy_o, j < total);
      check(done_o == (j == total), "R6 done", done_o, j == total);
      check(pattern_o == exp_pat && length_o == 3'(len),
            (ignore_at >= 0) ? "R7 display" : "R1 display",
            {pattern_o, 1'b0, length_o}, {exp_pat, 1'b0, 3'(len)});
      if (j == ignore_at) begin start_i = 1'b1; letter_i = 5'd4; end
      if (j == ignore_at + 1) begin start_i = 1'b0; letter_i = 5'(code); end
      @(negedge clk);
    end
    check(!done_o, "R6 done single", done_o, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!tone_o && !busy_o && !done_o, "R9 reset outputs", {tone_o, busy_o, done_o}, 0);
    check(pattern_o == 0 && length_o == 0, "R9 reset display", {pattern_o, 1'b0, length_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 32; c++) play(c, (c % 3) + 1, -1);
    play(16, 2, 5);
    play(9, 1, 20);
    // reset in the middle of a letter
    letter_i = 5'd14;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(!tone_o && !busy_o, "R9 mid reset", {tone_o, busy_o}, 0);
    check(pattern_o == 0 && length_o == 0, "R9 mid reset display", {pattern_o, 1'b0, length_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o, "R9 idle after reset", busy_o, 0);
    play(4, 1, -1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule